// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is the serial control port of a reference-clock generator. An external two-wire bus master (SMBus/I2C style, open-drain data line) reads and writes a bank of thirteen byte-wide registers. The register outputs set the per-output enables, the spread enable, the spread shape, the test controls and a 3-bit output-level code. SCL and SDA are sampled on a much faster system clock. Each line goes through a two-flop synchronizer and a glitch filter before START, STOP and bit edges are detected.

The command byte picks between two kinds of access. With its top bit set, the access goes to the one register named by the low seven bits. With its top bit clear, the access is a sequential block that starts at offset 0. A block write carries a count byte and then the data. A block read answers with the programmable count register first and then the registers in ascending order. The master may stop a block after any whole byte.

Top module: `smb_regbank_slave`

## Requirements
- R1: After reset the registers hold these values: offset 0 = 00h, 1 = 05h, 2 = FFh, 3 = FFh, 4 = FFh, 5 = 00h, 6 = 00h, 7 = 38h, 8 = 83h, 9 = 25h, 10 = 03h, 11 = 0Dh, 12 = 0Eh.
- R2: The slave ACKs (pulls SDA low in the ninth bit) only the address byte D2h (write) or D3h (read), that is 7-bit 69h with R/W in bit 0. Any other address gets a NACK, and SDA stays released for every later bit until the next START.
- R3: Byte write: address D2h, a command with bit 7 = 1 and the offset in bits 6:0, then one data byte. The data byte is written to that offset and all three bytes are ACKed.
- R4: Byte read: address D2h, a command with bit 7 = 1, a repeated START, then address D3h. The slave returns the indexed register MSB first.
- R5: Block write: address D2h, command 00h, a count byte N, then N data bytes. The data bytes go to offsets 0, 1, 2, ... in that order, and every byte is ACKed.
- R6: Block read: address D2h, command 00h, a repeated START, then address D3h. The slave first returns the value of offset 12, then the registers from offset 0 upward, for as long as the master ACKs. After a NACK the slave releases SDA.
- R7: Offset 12 is fully writable, and a block read returns its current value as the leading count byte.
- R8: Only these bits are writable: offset 1 bit 6; offset 4 bits 6, 5, 3, 2, 1; offset 9 bits 4:0; offset 12 bits 7:0. All other bits (including the identification byte at offset 7, revision in bits 7:4 and vendor in bits 3:0) keep their reset value. Offsets above 12 read as 00h.
- R9: Output ports: out_en[0..3] = offset 4 bits 6, 5, 3, 2; spread_en = offset 4 bit 1; spread_center = offset 1 bit 6; test_ref_sel = offset 9 bit 4; test_enter = offset 9 bit 3; out_level = offset 9 bits 2:0.
- R10: A STOP or START before the eighth data bit of a byte has been clocked in and acknowledged aborts the transfer without writing that byte. In a block write ended by STOP, the bytes already completed stay written.
- R11: Bytes move MSB first. SDA is pulled low only while the filtered SCL is low, and the filtered line changes only after the synchronized input has held its new level for FILT_LEN samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| out_en | output | 4 | Enables for the four reference outputs |
| spread_en | output | 1 | Spread modulation enable |
| spread_center | output | 1 | 1 = center spread, 0 = down spread |
| test_ref_sel | output | 1 | Test mode choice: 1 = divided reference, 0 = tri-state |
| test_enter | output | 1 | Test mode entry |
| out_level | output | 3 | Output swing code |

## Verification
A wrong bit counter or byte role shows up at the ninth clock of the same byte. The ACK appears one bit early or late, or is missing, and the bench reads it on SDA right away. A bad write mask, a bad pointer increment or a bad count load stays hidden until the next read of that offset. The bench therefore reads back after every write, walking each offset in both byte and block modes, and checks the mapped output ports within a transaction of the write.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} smb_state_e;
  typedef enum logic [1:0] {RL_ADDR, RL_CMD, RL_CNT, RL_DATA} smb_role_e;

  localparam int unsigned IDX_MODE  = 1;
  localparam int unsigned IDX_OUT   = 4;
  localparam int unsigned IDX_TEST  = 9;
  localparam int unsigned IDX_COUNT = 12;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      1:       return 8'h05;
      2, 3, 4: return 8'hFF;
      7:       return 8'h38;
      8:       return 8'h83;
      9:       return 8'h25;
      10:      return 8'h03;
      11:      return 8'h0D;
      12:      return 8'h0E;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      1:       return 8'h40;
      4:       return 8'h6E;
      9:       return 8'h1F;
      12:      return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      q    <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == q) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        q   <= sync[1];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> ($past(sync[1]) == q)); // R11

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 13,
  parameter int unsigned AW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [3:0]    out_en,
  output logic          spread_en,
  output logic          spread_center,
  output logic          test_ref_sel,
  output logic          test_enter,
  output logic [2:0]    out_level
);
  logic [7:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] WMASK = reg_wmask(i);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= reg_default(i);
      else if (wr_en && wr_addr == AW'(i))
        q <= (wr_data & WMASK) | (q & ~WMASK);
    end
    assign regs[i] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == AW'(i)) rd_data = regs[i];
  end

  assign out_en        = {regs[IDX_OUT][2], regs[IDX_OUT][3], regs[IDX_OUT][5], regs[IDX_OUT][6]};
  assign spread_en     = regs[IDX_OUT][1];
  assign spread_center = regs[IDX_MODE][6];
  assign test_ref_sel  = regs[IDX_TEST][4];
  assign test_enter    = regs[IDX_TEST][3];
  assign out_level     = regs[IDX_TEST][2:0];

endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
  import smb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned FILT_LEN = 3,
  parameter int unsigned NUM_REGS = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [3:0] out_en,
  output logic       spread_en,
  output logic       spread_center,
  output logic       test_ref_sel,
  output logic       test_enter,
  output logic [2:0] out_level
);
  localparam int unsigned AW = 7;

  logic scl_f, sda_f, scl_d, sda_d;
  logic start_c, stop_c, rise_c, fall_c;

  smb_state_e state;
  smb_role_e  role;
  logic [3:0]    bitcnt;
  logic [7:0]    sh;
  logic [AW-1:0] ptr;
  logic [7:0]    wr_left;
  logic          cnt_pending, go_tx, mnack;
  logic          wr_en_q;
  logic [AW-1:0] wr_addr_q;
  logic [7:0]    wr_data_q;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  smb_line_filter #(.FILT_LEN(FILT_LEN)) u_scl (.clk(clk), .rst(rst), .din(scl_i), .q(scl_f));
  smb_line_filter #(.FILT_LEN(FILT_LEN)) u_sda (.clk(clk), .rst(rst), .din(sda_i), .q(sda_f));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign start_c = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c  = scl_f & scl_d & ~sda_d & sda_f;
  assign rise_c  = scl_f & ~scl_d;
  assign fall_c  = ~scl_f & scl_d;
  assign rd_addr = cnt_pending ? AW'(IDX_COUNT) : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      role        <= RL_ADDR;
      bitcnt      <= '0;
      sh          <= '0;
      ptr         <= '0;
      wr_left     <= '0;
      cnt_pending <= 1'b0;
      go_tx       <= 1'b0;
      mnack       <= 1'b0;
      sda_oe      <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_c) begin
        state  <= ST_RX;
        role   <= RL_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (rise_c && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (fall_c && bitcnt == 4'd8) begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
              go_tx  <= 1'b0;
              case (role)
                RL_ADDR: begin
                  if (sh[7:1] != DEV_ADDR) begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                  end else begin
                    go_tx <= sh[0];
                    role  <= RL_CMD;
                  end
                end
                RL_CMD: begin
                  ptr         <= sh[7] ? sh[6:0] : '0;
                  cnt_pending <= ~sh[7];
                  wr_left     <= 8'd1;
                  role        <= sh[7] ? RL_DATA : RL_CNT;
                end
                RL_CNT: begin
                  wr_left     <= sh;
                  cnt_pending <= 1'b0;
                  role        <= RL_DATA;
                end
                default: begin
                  if (wr_left != 8'd0) begin
                    wr_en_q   <= 1'b1;
                    wr_addr_q <= ptr;
                    wr_data_q <= sh;
                    ptr       <= ptr + 1'b1;
                    wr_left   <= wr_left - 1'b1;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (fall_c) begin
              bitcnt <= '0;
              if (go_tx) begin
                state  <= ST_TX;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                if (cnt_pending) cnt_pending <= 1'b0;
                else             ptr <= ptr + 1'b1;
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (fall_c) begin
              if (bitcnt == 4'd7) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
                bitcnt <= '0;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (rise_c) begin
              mnack <= sda_f;
            end else if (fall_c) begin
              if (mnack) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_TX;
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                if (cnt_pending) cnt_pending <= 1'b0;
                else             ptr <= ptr + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .AW(AW)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_q), .wr_addr(wr_addr_q), .wr_data(wr_data_q),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .out_en(out_en), .spread_en(spread_en), .spread_center(spread_center),
    .test_ref_sel(test_ref_sel), .test_enter(test_enter), .out_level(out_level)
  );

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f); // R11

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R2

  AST_ACK_WHOLE_BYTE: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && state == ST_ACK) |-> ($past(bitcnt) == 4'd8)); // R10

  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK) |-> !sda_oe); // R6

endmodule

// File: tb/sim_smb_regbank_slave.sv
module sim_smb_regbank_slave;
  localparam int Q = 8;
  localparam int NREG = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [3:0] out_en;
  logic spread_en, spread_center, test_ref_sel, test_enter;
  logic [2:0] out_level;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [NREG];
  logic ack_ok;

  always #5 clk = ~clk;

  smb_regbank_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .out_en(out_en), .spread_en(spread_en), .spread_center(spread_center),
    .test_ref_sel(test_ref_sel), .test_enter(test_enter), .out_level(out_level)
  );

  function automatic logic [7:0] dflt(input int i);
    logic [7:0] t [NREG] = '{8'h00, 8'h05, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00,
                            8'h38, 8'h83, 8'h25, 8'h03, 8'h0D, 8'h0E};
    return t[i];
  endfunction

  function automatic logic [7:0] msk(input int i);
    return (i == 1) ? 8'h40 : (i == 4) ? 8'h6E : (i == 9) ? 8'h1F : (i == 12) ? 8'hFF : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    wait_n(Q); sda_m = b;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); s = sda_line;
    wait_n(Q); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(Q); sda_m = 1'b0;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); sda_m = 1'b1;
    wait_n(2 * Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(last, s);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d);
    logic a;
    ack_ok = 1'b1;
    bus_start();
    wbyte(8'hD2, a); ack_ok &= a;
    wbyte(8'h80 | 8'(off), a); ack_ok &= a;
    wbyte(d, a); ack_ok &= a;
    bus_stop();
    if (off < NREG) mdl[off] = (d & msk(off)) | (mdl[off] & ~msk(off));
  endtask

  task automatic byte_read(input int off, output logic [7:0] d);
    logic a;
    ack_ok = 1'b1;
    bus_start();
    wbyte(8'hD2, a); ack_ok &= a;
    wbyte(8'h80 | 8'(off), a); ack_ok &= a;
    bus_start();
    wbyte(8'hD3, a); ack_ok &= a;
    rbyte(1'b1, d);
    bus_stop();
  endtask

  task automatic check_reg(input int off, input string tag);
    logic [7:0] d;
    byte_read(off, d);
    chk(d == ((off < NREG) ? mdl[off] : 8'h00), tag, d, (off < NREG) ? mdl[off] : 8'h00);
  endtask

  task automatic check_ports(input string tag);
    logic [7:0] r4, r9;
    r4 = mdl[4]; r9 = mdl[9];
    chk(out_en == {r4[2], r4[3], r4[5], r4[6]}, {tag, " R9 out_en"}, {4'h0, out_en}, {4'h0, r4[2], r4[3], r4[5], r4[6]});
    chk(spread_en == r4[1] && spread_center == mdl[1][6], {tag, " R9 spread"},
        {6'h0, spread_en, spread_center}, {6'h0, r4[1], mdl[1][6]});
    chk({test_ref_sel, test_enter, out_level} == r9[4:0], {tag, " R9 test/level"},
        {3'h0, test_ref_sel, test_enter, out_level}, {3'h0, r9[4:0]});
  endtask

  task automatic block_read(input int n, input string tag);
    logic a;
    logic [7:0] d;
    ack_ok = 1'b1;
    bus_start();
    wbyte(8'hD2, a); ack_ok &= a;
    wbyte(8'h00, a); ack_ok &= a;
    bus_start();
    wbyte(8'hD3, a); ack_ok &= a;
    rbyte(1'b0, d);
    chk(d == mdl[12], {tag, " count first"}, d, mdl[12]);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, d);
      chk(d == mdl[i], tag, d, mdl[i]);
    end
    bus_stop();
    chk(ack_ok, {tag, " acks"}, {7'h0, ack_ok}, 8'h01);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] d;
    logic [7:0] pats [2] = '{8'hA5, 8'h5A};
    for (int i = 0; i < NREG; i++) mdl[i] = dflt(i);
    wait_n(10);
    rst = 1'b0;
    wait_n(4);

    chk(!sda_oe, "R1 sda released", {7'h0, sda_oe}, 8'h00);
    check_ports("R1 reset");
    for (int i = 0; i < NREG; i++) check_reg(i, "R1 R4 default");
    chk(ack_ok, "R2 R4 acks", {7'h0, ack_ok}, 8'h01);
    check_reg(20, "R8 out of range");

    // R3 R8 R9: sweep every offset with two patterns
    foreach (pats[p]) begin
      for (int i = 0; i < NREG; i++) begin
        byte_write(i, pats[p]);
        chk(ack_ok, "R3 write acks", {7'h0, ack_ok}, 8'h01);
        check_reg(i, "R3 R8 readback");
        if (i == 4 || i == 9) check_ports("R3 sweep");
      end
    end
    check_reg(7, "R8 id read-only");

    // R2: foreign address is NACKed, later bytes too
    bus_start();
    wbyte(8'hD0, a);
    chk(!a, "R2 foreign addr nack", {7'h0, a}, 8'h00);
    wbyte(8'h89, a);
    chk(!a, "R2 released after mismatch", {7'h0, a}, 8'h00);
    wbyte(8'h00, a);
    bus_stop();
    check_reg(9, "R2 no write on mismatch");

    // R10: STOP after four data bits
    bus_start();
    wbyte(8'hD2, a);
    wbyte(8'h89, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_stop();
    check_reg(9, "R10 aborted byte");

    // R5: full block write
    ack_ok = 1'b1;
    bus_start();
    wbyte(8'hD2, a); ack_ok &= a;
    wbyte(8'h00, a); ack_ok &= a;
    wbyte(8'(NREG), a); ack_ok &= a;
    for (int i = 0; i < NREG; i++) begin
      d = (i == 12) ? 8'd13 : 8'(i * 17 + 3);
      wbyte(d, a); ack_ok &= a;
      mdl[i] = (d & msk(i)) | (mdl[i] & ~msk(i));
    end
    bus_stop();
    chk(ack_ok, "R5 block write acks", {7'h0, ack_ok}, 8'h01);
    check_ports("R5 block");
    check_reg(9, "R5 offset 9");

    // R6: block read returns count then all registers
    block_read(NREG, "R6 block read");

    // R7: shorten the count
    byte_write(12, 8'h03);
    block_read(3, "R7 short count");

    // R10: block write ended after two bytes
    bus_start();
    wbyte(8'hD2, a);
    wbyte(8'h00, a);
    wbyte(8'h05, a);
    wbyte(8'hFF, a);
    wbyte(8'h40, a);
    mdl[1] = (8'h40 & msk(1)) | (mdl[1] & ~msk(1));
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop();
    check_reg(1, "R10 partial block kept");
    check_ports("R10 partial block");
    check_reg(9, "R10 later offsets untouched");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule